// File: doc/BRIEF.md
# Byte-Wide Flash Write and Erase Sequencer

This controller sits on the host side of a byte-wide parallel flash device and turns a single request into the full bus protocol that the device expects. A request carries an operation, an address and a data byte, and a one-cycle start pulse launches it. A program request sends three unlock/command writes and then the data byte to the target address. An erase request sends a six-write unlock-and-confirm sequence. The controller then reads the device repeatedly until the device reports completion, and it ends the request with a one-cycle done or error pulse.

Every bus access is built from registered strobes with widths set by parameters in clock cycles. For writes, write-enable is pulsed low while chip-enable is low and output-enable is high. For reads, chip-enable and output-enable are pulsed low together. Each strobe is followed by a minimum high recovery time. Address and write data are held for the whole access, and the data bus is driven only during writes.

Completion is detected in two ways. For a program, the controller watches bit 7: a busy device returns the inverse of the written bit 7. For an erase, it watches bit 6, which toggles on every read while the device is busy. If the device does not finish within a set number of poll reads, the controller gives up and reports an error.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A program request (op = 0) issues exactly four bus writes in this order: AAh to address 5555h, 55h to 2AAAh, A0h to 5555h, then the request data to the request address.
- R2: An erase request (op = 1) issues exactly six bus writes in this order: AAh/5555h, 55h/2AAAh, 80h/5555h, AAh/5555h, 55h/2AAAh, 10h/5555h.
- R3: Each bus write holds we_n low for exactly WR_LO cycles. During that time ce_n is low, oe_n is high and the data bus is driven. Between two write pulses, we_n stays high for at least WR_HI cycles.
- R4: fl_addr and fl_dout do not change while we_n is low.
- R5: After a program sequence, the controller reads the target address. It pulses done on the first read whose bit 7 equals bit 7 of the request data, so a device that stays busy for N status reads costs N+1 reads.
- R6: After an erase sequence, the controller reads the request address. It pulses done on the first read whose bit 6 equals bit 6 of the read just before it.
- R7: Each poll read holds ce_n and oe_n low together for exactly RD_LO cycles, with we_n high and the data bus released. Between two reads, oe_n stays high for at least RD_HI cycles.
- R8: If POLL_MAX poll reads pass without completion, the controller pulses error and not done, and busy falls in the same cycle.
- R9: A start pulse while busy is high is ignored: it issues no bus write and does not change the request in progress.
- R10: After reset, and whenever busy is low, ce_n, oe_n and we_n are high. done and error are single-cycle pulses, never high together, and each request ends with exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request launch, accepted only when idle |
| op | input | 1 | 0 = program one byte, 1 = erase the whole device |
| addr | input | AW | Target address (program target / erase poll address) |
| wdata | input | DW | Byte to program |
| busy | output | 1 | High from acceptance until done or error |
| done | output | 1 | One-cycle pulse: request completed |
| error | output | 1 | One-cycle pulse: poll limit reached |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | DW | Flash write data |
| fl_din | input | DW | Flash read data |
| fl_dq_oe | output | 1 | High while the controller drives the data bus |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
On every cycle, the assertions check the strobe discipline: the exact low widths of write and read pulses, the minimum high gaps between them, the rule that output-enable and write-enable are never both low, that the bus is held stable and the data bus is owned correctly during writes, and the pulse rules for done and error. Only the bench scenarios, run against a behavioural flash model, can show the rest. That includes the order and content of the unlock writes, the polling verdicts on bit 7 and bit 6, the exact number of poll reads, the final array contents, the timeout, and the rejection of a start pulse during a request.

// File: rtl/flprog_pkg.sv
package flprog_pkg;

   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } flprog_op_e;

   localparam int STEP_W = 3;

   localparam logic [15:0] KEY_ADDR_HI = 16'h5555;
   localparam logic [15:0] KEY_ADDR_LO = 16'h2AAA;
   localparam logic [7:0]  KEY_BYTE_1  = 8'hAA;
   localparam logic [7:0]  KEY_BYTE_2  = 8'h55;
   localparam logic [7:0]  CMD_WRITE   = 8'hA0;
   localparam logic [7:0]  CMD_ARM     = 8'h80;
   localparam logic [7:0]  CMD_WIPE    = 8'h10;

   // index of the final write in each sequence
   function automatic logic [STEP_W-1:0] final_step(flprog_op_e op);
      return (op == OP_ERASE) ? 3'd5 : 3'd3;
   endfunction

   // steps 1 and 4 go to the low key address, all others to the high one
   function automatic logic [15:0] key_addr(logic [STEP_W-1:0] step);
      case (step)
         3'd1, 3'd4: key_addr = KEY_ADDR_LO;
         default:    key_addr = KEY_ADDR_HI;
      endcase
   endfunction

   function automatic logic [7:0] key_byte(flprog_op_e op, logic [STEP_W-1:0] step);
      case (step)
         3'd0, 3'd3: key_byte = KEY_BYTE_1;
         3'd1, 3'd4: key_byte = KEY_BYTE_2;
         3'd2:       key_byte = (op == OP_PROGRAM) ? CMD_WRITE : CMD_ARM;
         default:    key_byte = CMD_WIPE;
      endcase
   endfunction

endpackage

// File: rtl/flprog_bus.sv
module flprog_bus #(
   parameter int AW    = 18,
   parameter int DW    = 8,
   parameter int WR_LO = 10,
   parameter int WR_HI = 5,
   parameter int RD_LO = 6,
   parameter int RD_HI = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          rd,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] din,
   output logic          ack,
   output logic [DW-1:0] rdata,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_dout,
   output logic          bus_drive,
   output logic          ce_n,
   output logic          oe_n,
   output logic          we_n
);

   localparam int TMAX = (WR_LO > WR_HI ? WR_LO : WR_HI) > (RD_LO > RD_HI ? RD_LO : RD_HI) ?
                         (WR_LO > WR_HI ? WR_LO : WR_HI) : (RD_LO > RD_HI ? RD_LO : RD_HI);
   localparam int CW = $clog2(TMAX + 1);
   localparam logic [CW-1:0] T_WLO = CW'(WR_LO - 1);
   localparam logic [CW-1:0] T_WHI = CW'(WR_HI - 1);
   localparam logic [CW-1:0] T_RLO = CW'(RD_LO - 1);
   localparam logic [CW-1:0] T_RHI = CW'(RD_HI - 1);

   typedef enum logic [1:0] {B_IDLE, B_SETUP, B_LOW, B_REC} bst_e;

   bst_e          st;
   logic [CW-1:0] tmr;
   logic          is_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= B_IDLE;
         tmr       <= '0;
         is_rd     <= 1'b0;
         ack       <= 1'b0;
         rdata     <= '0;
         bus_addr  <= '0;
         bus_dout  <= '0;
         bus_drive <= 1'b0;
         ce_n      <= 1'b1;
         oe_n      <= 1'b1;
         we_n      <= 1'b1;
      end else begin
         ack <= 1'b0;
         case (st)
            B_IDLE: if (go) begin
               bus_addr  <= addr;
               bus_dout  <= wdata;
               is_rd     <= rd;
               bus_drive <= !rd;
               st        <= B_SETUP;
            end
            B_SETUP: begin
               ce_n <= 1'b0;
               if (is_rd) oe_n <= 1'b0;
               else       we_n <= 1'b0;
               tmr <= is_rd ? T_RLO : T_WLO;
               st  <= B_LOW;
            end
            B_LOW: begin
               if (tmr == '0) begin
                  ce_n <= 1'b1;
                  oe_n <= 1'b1;
                  we_n <= 1'b1;
                  if (is_rd) rdata <= din;
                  tmr <= is_rd ? T_RHI : T_WHI;
                  st  <= B_REC;
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
            default: begin
               if (tmr == '0) begin
                  ack       <= 1'b1;
                  bus_drive <= 1'b0;
                  st        <= B_IDLE;
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/flprog_status.sv
module flprog_status
   import flprog_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          sample,
   input  flprog_op_e    op,
   input  logic          want7,
   input  logic [DW-1:0] rdata,
   output logic          complete
);

   logic prev6;
   logic have_prev;

   always_comb begin
      if (op == OP_PROGRAM) complete = sample && (rdata[7] == want7);
      else                  complete = sample && have_prev && (rdata[6] == prev6);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev6     <= 1'b0;
         have_prev <= 1'b0;
      end else if (clear) begin
         have_prev <= 1'b0;
      end else if (sample) begin
         prev6     <= rdata[6];
         have_prev <= 1'b1;
      end
   end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import flprog_pkg::*;
#(
   parameter int AW       = 18,
   parameter int DW       = 8,
   parameter int WR_LO    = 10,
   parameter int WR_HI    = 5,
   parameter int RD_LO    = 6,
   parameter int RD_HI    = 15,
   parameter int POLL_MAX = 4096
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          op,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          busy,
   output logic          done,
   output logic          error,
   output logic [AW-1:0] fl_addr,
   output logic [DW-1:0] fl_dout,
   input  logic [DW-1:0] fl_din,
   output logic          fl_dq_oe,
   output logic          fl_ce_n,
   output logic          fl_oe_n,
   output logic          fl_we_n
);

   localparam int PCW = $clog2(POLL_MAX + 1);
   localparam logic [PCW-1:0] P_LAST = PCW'(POLL_MAX - 1);

   generate
      if (AW < 16) begin : g_bad_aw
         $error("flash_prog_ctrl: AW must cover the key addresses (>= 16)");
      end
      if (DW < 8) begin : g_bad_dw
         $error("flash_prog_ctrl: DW must be at least 8");
      end
      if (WR_LO < 1 || WR_HI < 1 || RD_LO < 1 || RD_HI < 1) begin : g_bad_tm
         $error("flash_prog_ctrl: strobe widths must be at least one cycle");
      end
      if (POLL_MAX < 2) begin : g_bad_pm
         $error("flash_prog_ctrl: POLL_MAX must be at least 2");
      end
   endgenerate

   typedef enum logic [2:0] {T_IDLE, T_CMD, T_CMDW, T_POLL, T_POLLW} tst_e;

   tst_e               st;
   flprog_op_e         op_q;
   logic [AW-1:0]      tgt;
   logic [DW-1:0]      wd;
   logic [STEP_W-1:0]  step;
   logic [PCW-1:0]     pcnt;

   logic               b_go, b_rd, b_ack;
   logic [AW-1:0]      b_addr;
   logic [DW-1:0]      b_data, b_rdata;
   logic               data_step, complete, st_clear, st_sample;

   assign data_step = (op_q == OP_PROGRAM) && (step == final_step(OP_PROGRAM));
   assign b_go      = (st == T_CMD) || (st == T_POLL);
   assign b_rd      = (st == T_POLL);
   assign b_addr    = (b_rd || data_step) ? tgt : AW'(key_addr(step));
   assign b_data    = data_step ? wd : DW'(key_byte(op_q, step));
   assign st_clear  = (st == T_CMDW) && b_ack && (step == final_step(op_q));
   assign st_sample = (st == T_POLLW) && b_ack;
   assign busy      = (st != T_IDLE);

   flprog_bus #(
      .AW(AW), .DW(DW), .WR_LO(WR_LO), .WR_HI(WR_HI), .RD_LO(RD_LO), .RD_HI(RD_HI)
   ) u_bus (
      .clk(clk), .rst_n(rst_n), .go(b_go), .rd(b_rd), .addr(b_addr), .wdata(b_data),
      .din(fl_din), .ack(b_ack), .rdata(b_rdata), .bus_addr(fl_addr), .bus_dout(fl_dout),
      .bus_drive(fl_dq_oe), .ce_n(fl_ce_n), .oe_n(fl_oe_n), .we_n(fl_we_n)
   );

   flprog_status #(.DW(DW)) u_status (
      .clk(clk), .rst_n(rst_n), .clear(st_clear), .sample(st_sample), .op(op_q),
      .want7(wd[7]), .rdata(b_rdata), .complete(complete)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= T_IDLE;
         op_q  <= OP_PROGRAM;
         tgt   <= '0;
         wd    <= '0;
         step  <= '0;
         pcnt  <= '0;
         done  <= 1'b0;
         error <= 1'b0;
      end else begin
         done  <= 1'b0;
         error <= 1'b0;
         case (st)
            T_IDLE: if (start) begin
               op_q <= flprog_op_e'(op);
               tgt  <= addr;
               wd   <= wdata;
               step <= '0;
               st   <= T_CMD;
            end
            T_CMD:  st <= T_CMDW;
            T_CMDW: if (b_ack) begin
               if (step == final_step(op_q)) begin
                  pcnt <= '0;
                  st   <= T_POLL;
               end else begin
                  step <= step + 1'b1;
                  st   <= T_CMD;
               end
            end
            T_POLL: st <= T_POLLW;
            T_POLLW: if (b_ack) begin
               if (complete) begin
                  done <= 1'b1;
                  st   <= T_IDLE;
               end else if (pcnt == P_LAST) begin
                  error <= 1'b1;
                  st    <= T_IDLE;
               end else begin
                  pcnt <= pcnt + 1'b1;
                  st   <= T_POLL;
               end
            end
            default: st <= T_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flprog_chk.sv
module flprog_chk #(
   parameter int AW    = 18,
   parameter int DW    = 8,
   parameter int WR_LO = 10,
   parameter int WR_HI = 5,
   parameter int RD_LO = 6,
   parameter int RD_HI = 15
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          error,
   input logic [AW-1:0] fl_addr,
   input logic [DW-1:0] fl_dout,
   input logic          fl_dq_oe,
   input logic          fl_ce_n,
   input logic          fl_oe_n,
   input logic          fl_we_n
);

   localparam logic [15:0] SAT = 16'hFFFF;

   logic        we_q, oe_q, seen_w, seen_r;
   logic [15:0] wlo, whi, rlo, rhi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q <= 1'b1; oe_q <= 1'b1; seen_w <= 1'b0; seen_r <= 1'b0;
         wlo <= '0; whi <= '0; rlo <= '0; rhi <= '0;
      end else begin
         we_q <= fl_we_n;
         oe_q <= fl_oe_n;
         if (!fl_we_n) begin
            seen_w <= 1'b1;
            whi    <= '0;
            wlo    <= (wlo == SAT) ? wlo : wlo + 1'b1;
         end else begin
            wlo <= '0;
            whi <= (whi == SAT) ? whi : whi + 1'b1;
         end
         if (!fl_oe_n) begin
            seen_r <= 1'b1;
            rhi    <= '0;
            rlo    <= (rlo == SAT) ? rlo : rlo + 1'b1;
         end else begin
            rlo <= '0;
            rhi <= (rhi == SAT) ? rhi : rhi + 1'b1;
         end
      end
   end

   // R3
   we_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));
   // R3
   we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_we_n && !we_q) |-> (wlo == 16'(WR_LO)));
   // R3
   we_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n && we_q && seen_w) |-> (whi >= 16'(WR_HI)));
   // R4
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n && !we_q) |-> ($stable(fl_addr) && $stable(fl_dout)));
   // R7
   rd_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> (!fl_ce_n && fl_we_n && !fl_dq_oe));
   // R7
   rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_oe_n && !oe_q) |-> (rlo == 16'(RD_LO)));
   // R7
   rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_oe_n && oe_q && seen_r) |-> (rhi >= 16'(RD_HI)));
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (fl_ce_n && fl_oe_n && fl_we_n));
   // R10
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   error_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (!busy && $past(busy)));

endmodule

bind flash_prog_ctrl flprog_chk #(
   .AW(AW), .DW(DW), .WR_LO(WR_LO), .WR_HI(WR_HI), .RD_LO(RD_LO), .RD_HI(RD_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
   .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dq_oe(fl_dq_oe),
   .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/tb_flash_prog_ctrl.sv
module tb_flash_prog_ctrl;

   localparam int AW = 18;
   localparam int DW = 8;
   localparam int WL = 10;
   localparam int WH = 5;
   localparam int RL = 6;
   localparam int RH = 15;
   localparam int PM = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          op = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          busy, done, error;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_dout, fl_din;
   logic          fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

   always #5 clk = ~clk;

   flash_prog_ctrl #(
      .AW(AW), .DW(DW), .WR_LO(WL), .WR_HI(WH), .RD_LO(RL), .RD_HI(RH), .POLL_MAX(PM)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
      .busy(busy), .done(done), .error(error), .fl_addr(fl_addr), .fl_dout(fl_dout),
      .fl_din(fl_din), .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
      .fl_we_n(fl_we_n)
   );

   int n_chk = 0;
   int n_err = 0;

   // ---------------- behavioural flash model ----------------
   logic [7:0]    mem [int];
   int            ust = 0;
   bit            active = 0, stuck = 0, is_erase = 0, tog = 0;
   int            busy_left = 0, cfg_polls = 0;
   logic [AW-1:0] pa;
   logic [7:0]    pd;
   logic [7:0]    rd_q = 8'h00;
   logic [AW-1:0] log_a [0:15];
   logic [7:0]    log_d [0:15];
   int            nlog = 0, nreads = 0;

   // bus monitors
   logic          we_p = 1'b1, oe_p = 1'b1;
   logic [AW-1:0] a_p = '0;
   logic [7:0]    d_p = '0;
   int            we_lo = 0, we_hi = 1000, oe_lo = 0, oe_hi = 1000;
   int            bad_ww = 0, bad_wg = 0, bad_rw = 0, bad_rg = 0, bad_hold = 0, bad_own = 0;

   assign fl_din = (!fl_ce_n && !fl_oe_n) ? rd_q : 8'h00;

   function automatic logic [7:0] rdmem(logic [AW-1:0] a);
      return mem.exists(int'(a)) ? mem[int'(a)] : 8'hFF;
   endfunction

   task automatic finish_op();
      if (is_erase) mem.delete();
      else mem[int'(pa)] = rdmem(pa) & pd;
      active = 0;
   endtask

   task automatic begin_op(bit er, logic [AW-1:0] a, logic [7:0] d);
      is_erase = er; pa = a; pd = d; tog = 0;
      busy_left = cfg_polls; active = 1;
      if (cfg_polls == 0 && !stuck) finish_op();
   endtask

   task automatic model_write(logic [AW-1:0] a, logic [7:0] d);
      if (nlog < 16) begin log_a[nlog] = a; log_d[nlog] = d; end
      nlog++;
      if (active) return;
      case (ust)
         0: ust = (a == 18'h05555 && d == 8'hAA) ? 1 : 0;
         1: ust = (a == 18'h02AAA && d == 8'h55) ? 2 : 0;
         2: ust = (a == 18'h05555 && d == 8'hA0) ? 3 :
                  (a == 18'h05555 && d == 8'h80) ? 4 : 0;
         3: begin begin_op(0, a, d); ust = 0; end
         4: ust = (a == 18'h05555 && d == 8'hAA) ? 5 : 0;
         5: ust = (a == 18'h02AAA && d == 8'h55) ? 6 : 0;
         6: begin if (a == 18'h05555 && d == 8'h10) begin_op(1, a, d); ust = 0; end
         default: ust = 0;
      endcase
   endtask

   task automatic model_read(logic [AW-1:0] a);
      nreads++;
      if (active) begin
         tog = ~tog;
         rd_q = is_erase ? {1'b0, tog, 6'b0} : {~pd[7], tog, pd[5:0]};
         if (!stuck) begin
            busy_left--;
            if (busy_left <= 0) finish_op();
         end
      end else begin
         rd_q = rdmem(a);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (fl_we_n && !we_p) model_write(fl_addr, fl_dout);
         if (!fl_oe_n && oe_p && !fl_ce_n) model_read(fl_addr);
         // write strobe widths (R3) and hold (R4)
         if (!fl_we_n) begin
            if (we_p) begin
               if (we_hi < WH) bad_wg++;
               we_lo = 0;
            end else if (fl_addr != a_p || fl_dout != d_p) begin
               bad_hold++;
            end
            we_lo++;
         end else begin
            if (!we_p) begin
               if (we_lo != WL) bad_ww++;
               we_hi = 0;
            end
            we_hi++;
         end
         // read strobe widths (R7)
         if (!fl_oe_n) begin
            if (oe_p) begin
               if (oe_hi < RH) bad_rg++;
               oe_lo = 0;
            end
            oe_lo++;
         end else begin
            if (!oe_p) begin
               if (oe_lo != RL) bad_rw++;
               oe_hi = 0;
            end
            oe_hi++;
         end
         // bus ownership (R3, R7)
         if (!fl_oe_n && (fl_dq_oe || !fl_we_n || fl_ce_n)) bad_own++;
         if (!fl_we_n && (!fl_dq_oe || fl_ce_n)) bad_own++;
      end
      we_p = fl_we_n; oe_p = fl_oe_n; a_p = fl_addr; d_p = fl_dout;
   end

   // ---------------- checking helpers ----------------
   task automatic check(bit ok, string tag, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_op(input bit eop, input logic [AW-1:0] a, input logic [7:0] d,
                         input bit poke, output int nd, output int ne);
      nd = 0; ne = 0;
      nlog = 0; nreads = 0;
      @(negedge clk);
      op = eop; addr = a; wdata = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (poke && i == 30) begin
            start = 1'b1; op = ~eop; addr = a + 1'b1; wdata = 8'h00;
         end else begin
            start = 1'b0;
         end
         if (done) nd++;
         if (error) ne++;
         if (!busy) break;
      end
      start = 1'b0;
      repeat (4) begin
         @(negedge clk);
         if (done) nd++;
         if (error) ne++;
      end
   endtask

   task automatic t_reset();
      check(busy == 1'b0 && done == 1'b0 && error == 1'b0, "R10 flags after reset",
            {busy, done, error}, 3'b000);
      check(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R10 strobes after reset",
            {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
   endtask

   task automatic t_program(logic [AW-1:0] a, logic [7:0] d, int polls, logic [7:0] exp_v);
      int nd, ne, mm;
      logic [AW-1:0] ea [0:3];
      logic [7:0]    ed [0:3];
      ea = '{18'h05555, 18'h02AAA, 18'h05555, a};
      ed = '{8'hAA, 8'h55, 8'hA0, d};
      cfg_polls = polls;
      run_op(1'b0, a, d, 1'b0, nd, ne);
      check(nd == 1 && ne == 0, "R5 program ends with one done", {nd[7:0], ne[7:0]}, 16'h0100);
      check(nlog == 4, "R1 program write count", nlog, 4);
      mm = 0;
      for (int i = 0; i < 4; i++) if (log_a[i] != ea[i] || log_d[i] != ed[i]) mm++;
      check(mm == 0, "R1 program write order", mm, 0);
      check(rdmem(a) == exp_v, "R5 programmed byte", rdmem(a), exp_v);
      check(nreads == polls + 1, "R5 poll read count", nreads, polls + 1);
   endtask

   task automatic t_erase(int polls);
      int nd, ne, mm, exp_r;
      logic [AW-1:0] ea [0:5];
      logic [7:0]    ed [0:5];
      ea = '{18'h05555, 18'h02AAA, 18'h05555, 18'h05555, 18'h02AAA, 18'h05555};
      ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
      cfg_polls = polls;
      run_op(1'b1, 18'h00000, 8'h00, 1'b0, nd, ne);
      check(nd == 1 && ne == 0, "R6 erase ends with one done", {nd[7:0], ne[7:0]}, 16'h0100);
      check(nlog == 6, "R2 erase write count", nlog, 6);
      mm = 0;
      for (int i = 0; i < 6; i++) if (log_a[i] != ea[i] || log_d[i] != ed[i]) mm++;
      check(mm == 0, "R2 erase write order", mm, 0);
      check(mem.num() == 0 && rdmem(18'h31234) == 8'hFF, "R6 array erased",
            rdmem(18'h31234), 8'hFF);
      // busy reads alternate bit 6; erased data has bit 6 = 1
      exp_r = (polls % 2 == 1) ? polls + 1 : polls + 2;
      check(nreads == exp_r, "R6 poll read count", nreads, exp_r);
   endtask

   task automatic t_busy_ignore();
      int nd, ne;
      cfg_polls = 3;
      run_op(1'b0, 18'h00100, 8'h3C, 1'b1, nd, ne);
      check(nd == 1 && ne == 0, "R9 request still completes", {nd[7:0], ne[7:0]}, 16'h0100);
      check(nlog == 4, "R9 no extra writes from start while busy", nlog, 4);
      check(rdmem(18'h00100) == 8'h3C && rdmem(18'h00101) == 8'hFF,
            "R9 only the original target changed", {rdmem(18'h00100), rdmem(18'h00101)}, 16'h3CFF);
      repeat (50) @(negedge clk);
      check(!busy && nlog == 4, "R9 ignored start not replayed", {busy, nlog[7:0]}, 0 * 256 + 4);
   endtask

   task automatic t_timeout();
      int nd, ne;
      stuck = 1;
      cfg_polls = 1;
      run_op(1'b1, 18'h00000, 8'h00, 1'b0, nd, ne);
      check(ne == 1 && nd == 0, "R8 timeout gives error only", {nd[7:0], ne[7:0]}, 16'h0001);
      check(nreads == PM, "R8 poll reads before timeout", nreads, PM);
      check(!busy && fl_ce_n && fl_oe_n && fl_we_n, "R8 R10 idle after timeout",
            {busy, fl_ce_n, fl_oe_n, fl_we_n}, 4'b0111);
      stuck = 0; active = 0;
   endtask

   task automatic t_bus_rules();
      check(bad_ww == 0, "R3 write low width", bad_ww, 0);
      check(bad_wg == 0, "R3 write high gap", bad_wg, 0);
      check(bad_hold == 0, "R4 address/data hold", bad_hold, 0);
      check(bad_rw == 0, "R7 read low width", bad_rw, 0);
      check(bad_rg == 0, "R7 read high gap", bad_rg, 0);
      check(bad_own == 0, "R3 R7 strobe framing and bus ownership", bad_own, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_program(18'h31234, 8'hA5, 3, 8'hA5);
      t_program(18'h00042, 8'h12, 0, 8'h12);
      t_program(18'h31234, 8'hF0, 2, 8'hA0);
      t_busy_ignore();
      t_erase(4);
      t_erase(3);
      t_timeout();
      t_program(18'h20000, 8'h81, 1, 8'h81);
      t_bus_rules();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule